// File: doc/BRIEF.md
# Indirect Clock-Synthesizer Register Port

This block holds the byte-wide control registers of a clock synthesizer behind a small host-facing window of four byte ports. A host never addresses the synthesizer registers directly. It first writes an address byte that carries a register index and a write-permit flag. A data-port access then reads or updates the register at that index. A separate clock-control port holds the index of the pixel clock in use.

The bank contains a general-control byte, a packed post-divider byte with one 2-bit code per pixel clock, an extended-control byte whose low bits choose the memory-clock divide source, and one 8-bit feedback divider for each of the four pixel clocks. From these registers the block decodes, at all times, the feedback divider and post-divider of the active pixel clock and the reference and post divide of the memory clock. It drives them to the analog synthesizer and the clock muxes outside the block.

A normal update takes three host writes: the address byte with the permit flag set, then the data byte, then the address byte again with the flag cleared. A read takes an address write with the flag cleared, followed by a read of the data port. Host reads are combinational: `host_rdata` always shows the port selected by `host_port`.

Top module: `pll_ixport`

## Requirements
- R1: After reset every bank register is zero, the stored index is 0, the write permit is clear and the active clock is 0. All decoded outputs follow from those values.
- R2: A write to port 0 stores the register index from bits 7:2 and the write permit from bit 1. Bit 0 is discarded. A read of port 0 returns {index, permit, 0}.
- R3: A port-1 write while the permit is set replaces the register at the stored index with the written byte, starting with the next cycle.
- R4: A port-1 write while the permit is clear changes no register.
- R5: A read of port 1 returns the register at the stored index. Indices 0 and 8 to 63 hold no register, read as zero, and ignore writes.
- R6: Index 2 is the post-divider byte. The code for pixel clock n sits at bits 2n+1:2n. `act_post_code` is the code of the active clock, and `act_post_ratio` is one-hot 1<<code, giving a divide by 1, 2, 4 or 8.
- R7: Indices 4, 5, 6 and 7 are the feedback dividers of pixel clocks 0 to 3. `act_fb_div` is the divider of the active clock.
- R8: A port-2 write sets the active clock from bits 1:0. A port-2 read returns the active clock in bits 1:0 with zeros above. Port 3 reads as zero and ignores writes.
- R9: Index 3 is the extended-control byte. Its bits 2:0 decode the memory clock as follows. Codes 0 to 3 give a reference divide of 1 and a post code equal to the value. Code 4 gives a reference divide of 3 and post code 0. Codes 5 to 7 raise `mem_src_bad` and give a reference divide of 1 and post code 0.
- R10: Index 1 is the general-control byte, driven unchanged on `gen_ctl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host and register clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_port | input | 2 | Port select: 0 address, 1 data, 2 clock control, 3 unused |
| host_we | input | 1 | Host write strobe for the selected port |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read byte of the selected port |
| act_clk | output | 2 | Active pixel-clock index |
| act_fb_div | output | 8 | Feedback divider of the active clock |
| act_post_code | output | 2 | Post-divider code of the active clock |
| act_post_ratio | output | 4 | One-hot post divide ratio of the active clock |
| mem_ref_div | output | 2 | Memory-clock reference divide, 1 or 3 |
| mem_post_code | output | 2 | Memory-clock post-divider code |
| mem_src_bad | output | 1 | Unsupported memory-clock source code |
| gen_ctl | output | 8 | General-control register |

## Verification
The bench sets the permit and then clears it again before a data write. A design that latched the permit only on a rising flag, or ignored the flag, would corrupt a register, and the model catches it on the next cycle. It writes to index 0 and to indices above the last divider. A loose index decode would alias these writes onto a real register, or return garbage on a read instead of zero. It walks the active clock through all four values over a post byte with four distinct codes, so a field placed at n instead of 2n, or a swapped divider order, shows at once. It also drives all eight extended-control codes, including code 4 and the unsupported codes above it, and sets bit 0 and the upper clock-control bits to confirm they are dropped.

// File: rtl/pll_ixport_pkg.sv
package pll_ixport_pkg;

  localparam int DATA_W   = 8;
  localparam int IDX_W    = 6;
  localparam int N_CLK    = 4;
  localparam int CODE_W   = 2;
  localparam int IDX_GEN  = 1;
  localparam int IDX_POST = 2;
  localparam int IDX_EXT  = 3;
  localparam int IDX_FB0  = 4;

  typedef enum logic [1:0] {
    PORT_ADDR = 2'd0,
    PORT_DATA = 2'd1,
    PORT_CLK  = 2'd2,
    PORT_NONE = 2'd3
  } port_e;

  typedef struct packed {
    logic [1:0] ref_div;
    logic [1:0] post_code;
    logic       bad;
  } mem_src_t;

  // one-hot divide ratio from a 2-bit post code
  function automatic logic [3:0] post_ratio(input logic [1:0] code);
    return 4'(1) << code;
  endfunction

  // memory-clock source decode from the low three extended-control bits
  function automatic mem_src_t decode_mem_src(input logic [2:0] code);
    mem_src_t r;
    r.ref_div   = 2'd1;
    r.post_code = 2'd0;
    r.bad       = 1'b0;
    if (code < 3'd4) begin
      r.post_code = code[1:0];
    end else if (code == 3'd4) begin
      r.ref_div = 2'd3;
    end else begin
      r.bad = 1'b1;
    end
    return r;
  endfunction

endpackage

// File: rtl/pll_addr_latch.sv
module pll_addr_latch #(
  parameter int IDX_W = pll_ixport_pkg::IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_wr,
  input  logic [IDX_W+1:1] addr_byte,
  output logic [IDX_W-1:0] idx,
  output logic             wr_en
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx   <= '0;
      wr_en <= 1'b0;
    end else if (addr_wr) begin
      idx   <= addr_byte[IDX_W+1:2];
      wr_en <= addr_byte[1];
    end
  end

  // R2
  addr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_wr |=> (idx == $past(addr_byte[IDX_W+1:2])) && (wr_en == $past(addr_byte[1])));

endmodule

// File: rtl/pll_reg_bank.sv
module pll_reg_bank
  import pll_ixport_pkg::*;
#(
  parameter int DW    = DATA_W,
  parameter int IW    = IDX_W,
  parameter int NCLK  = N_CLK
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     data_wr,
  input  logic                     wr_en,
  input  logic [IW-1:0]            idx,
  input  logic [DW-1:0]            wdata,
  output logic [DW-1:0]            gen_q,
  output logic [DW-1:0]            post_q,
  output logic [DW-1:0]            ext_q,
  output logic [NCLK-1:0][DW-1:0]  fb_q,
  output logic [DW-1:0]            rd_data
);

  logic            commit;
  logic            hit_gen, hit_post, hit_ext;
  logic [NCLK-1:0] hit_fb;

  assign commit   = data_wr && wr_en;
  assign hit_gen  = (idx == IW'(IDX_GEN));
  assign hit_post = (idx == IW'(IDX_POST));
  assign hit_ext  = (idx == IW'(IDX_EXT));

  for (genvar g = 0; g < NCLK; g++) begin : g_fb_hit
    assign hit_fb[g] = (idx == IW'(IDX_FB0 + g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q  <= '0;
      post_q <= '0;
      ext_q  <= '0;
      fb_q   <= '0;
    end else if (commit) begin
      if (hit_gen)  gen_q  <= wdata;
      if (hit_post) post_q <= wdata;
      if (hit_ext)  ext_q  <= wdata;
      for (int k = 0; k < NCLK; k++) begin
        if (hit_fb[k]) fb_q[k] <= wdata;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (hit_gen)  rd_data = gen_q;
    if (hit_post) rd_data = post_q;
    if (hit_ext)  rd_data = ext_q;
    for (int k = 0; k < NCLK; k++) begin
      if (hit_fb[k]) rd_data = fb_q[k];
    end
  end

  // R4
  locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !wr_en) |=> ($stable(gen_q) && $stable(post_q) && $stable(ext_q) && $stable(fb_q)));

  // R3
  gen_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && wr_en && idx == IW'(IDX_GEN)) |=> (gen_q == $past(wdata)));

endmodule

// File: rtl/pll_sel_decode.sv
module pll_sel_decode
  import pll_ixport_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int NCLK = N_CLK,
  parameter int SW   = $clog2(N_CLK)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [SW-1:0]           sel,
  input  logic [DW-1:0]           post_q,
  input  logic [NCLK-1:0][DW-1:0] fb_q,
  input  logic [2:0]              ext_code,
  output logic [DW-1:0]           act_fb_div,
  output logic [CODE_W-1:0]       act_post_code,
  output logic [3:0]              act_post_ratio,
  output logic [1:0]              mem_ref_div,
  output logic [1:0]              mem_post_code,
  output logic                    mem_src_bad
);

  mem_src_t mem_src;

  assign act_fb_div     = fb_q[sel];
  assign act_post_code  = post_q[CODE_W*sel +: CODE_W];
  assign act_post_ratio = post_ratio(act_post_code);

  assign mem_src       = decode_mem_src(ext_code);
  assign mem_ref_div   = mem_src.ref_div;
  assign mem_post_code = mem_src.post_code;
  assign mem_src_bad   = mem_src.bad;

  // R6
  ratio_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(act_post_ratio) == 1);

  // R9
  div3_post_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_ref_div == 2'd3) |-> (mem_post_code == 2'd0 && !mem_src_bad));

endmodule

// File: rtl/pll_ixport.sv
module pll_ixport
  import pll_ixport_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int IW   = IDX_W,
  parameter int NCLK = N_CLK,
  localparam int SW  = $clog2(NCLK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    host_port,
  input  logic          host_we,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic [SW-1:0] act_clk,
  output logic [DW-1:0] act_fb_div,
  output logic [1:0]    act_post_code,
  output logic [3:0]    act_post_ratio,
  output logic [1:0]    mem_ref_div,
  output logic [1:0]    mem_post_code,
  output logic          mem_src_bad,
  output logic [DW-1:0] gen_ctl
);

  port_e                   port;
  logic                    addr_wr, data_wr, clk_wr;
  logic [IW-1:0]           idx;
  logic                    wr_en;
  logic [DW-1:0]           post_q, ext_q, bank_rd;
  logic [NCLK-1:0][DW-1:0] fb_q;
  logic [SW-1:0]           sel_q;

  assign port    = port_e'(host_port);
  assign addr_wr = host_we && (port == PORT_ADDR);
  assign data_wr = host_we && (port == PORT_DATA);
  assign clk_wr  = host_we && (port == PORT_CLK);

  pll_addr_latch #(.IDX_W(IW)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_wr   (addr_wr),
    .addr_byte (host_wdata[IW+1:1]),
    .idx       (idx),
    .wr_en     (wr_en)
  );

  pll_reg_bank #(.DW(DW), .IW(IW), .NCLK(NCLK)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .data_wr (data_wr),
    .wr_en   (wr_en),
    .idx     (idx),
    .wdata   (host_wdata),
    .gen_q   (gen_ctl),
    .post_q  (post_q),
    .ext_q   (ext_q),
    .fb_q    (fb_q),
    .rd_data (bank_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (clk_wr) sel_q <= host_wdata[SW-1:0];
  end
  assign act_clk = sel_q;

  pll_sel_decode #(.DW(DW), .NCLK(NCLK), .SW(SW)) u_dec (
    .clk            (clk),
    .rst_n          (rst_n),
    .sel            (sel_q),
    .post_q         (post_q),
    .fb_q           (fb_q),
    .ext_code       (ext_q[2:0]),
    .act_fb_div     (act_fb_div),
    .act_post_code  (act_post_code),
    .act_post_ratio (act_post_ratio),
    .mem_ref_div    (mem_ref_div),
    .mem_post_code  (mem_post_code),
    .mem_src_bad    (mem_src_bad)
  );

  always_comb begin
    unique case (port)
      PORT_ADDR: host_rdata = {idx, wr_en, 1'b0};
      PORT_DATA: host_rdata = bank_rd;
      PORT_CLK:  host_rdata = DW'(sel_q);
      default:   host_rdata = '0;
    endcase
  end

  // R8
  clk_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_wr |=> (act_clk == $past(host_wdata[SW-1:0])));

  // R8
  clk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_wr |=> $stable(act_clk));

endmodule

// File: tb/tb_pll_ixport.sv
module tb_pll_ixport;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] host_port = 2'd0;
  logic       host_we = 1'b0;
  logic [7:0] host_wdata = 8'd0;
  logic [7:0] host_rdata;
  logic [1:0] act_clk;
  logic [7:0] act_fb_div;
  logic [1:0] act_post_code;
  logic [3:0] act_post_ratio;
  logic [1:0] mem_ref_div;
  logic [1:0] mem_post_code;
  logic       mem_src_bad;
  logic [7:0] gen_ctl;

  int checks = 0;
  int errors = 0;

  // reference state
  int m_idx, m_we, m_sel, m_gen, m_post, m_ext;
  int m_fb [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_ixport dut (
    .clk(clk), .rst_n(rst_n), .host_port(host_port), .host_we(host_we),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .act_clk(act_clk),
    .act_fb_div(act_fb_div), .act_post_code(act_post_code),
    .act_post_ratio(act_post_ratio), .mem_ref_div(mem_ref_div),
    .mem_post_code(mem_post_code), .mem_src_bad(mem_src_bad), .gen_ctl(gen_ctl)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int reg_at(input int i);
    if (i == 1) return m_gen;
    if (i == 2) return m_post;
    if (i == 3) return m_ext;
    if (i >= 4 && i <= 7) return m_fb[i-4];
    return 0;
  endfunction

  task automatic model_reset();
    m_idx = 0; m_we = 0; m_sel = 0; m_gen = 0; m_post = 0; m_ext = 0;
    for (int k = 0; k < 4; k++) m_fb[k] = 0;
  endtask

  task automatic model_step(input int p, input int we, input int d);
    if (!we) return;
    if (p == 0) begin
      m_idx = (d >> 2) & 63;
      m_we  = (d >> 1) & 1;
    end else if (p == 1 && m_we == 1) begin
      if (m_idx == 1) m_gen = d;
      else if (m_idx == 2) m_post = d;
      else if (m_idx == 3) m_ext = d;
      else if (m_idx >= 4 && m_idx <= 7) m_fb[m_idx-4] = d;
    end else if (p == 2) begin
      m_sel = d & 3;
    end
  endtask

  task automatic compare();
    int pc, ec, eref, epost, ebad, erd;
    pc = (m_post >> (2*m_sel)) & 3;
    ec = m_ext & 7;
    eref = 1; epost = 0; ebad = 0;
    if (ec < 4) epost = ec;
    else if (ec == 4) eref = 3;
    else ebad = 1;
    chk("R8", "act_clk", act_clk, m_sel);
    chk("R7", "act_fb_div", act_fb_div, m_fb[m_sel]);
    chk("R6", "act_post_code", act_post_code, pc);
    chk("R6", "act_post_ratio", act_post_ratio, 1 << pc);
    chk("R9", "mem_ref_div", mem_ref_div, eref);
    chk("R9", "mem_post_code", mem_post_code, epost);
    chk("R9", "mem_src_bad", mem_src_bad, ebad);
    chk("R10", "gen_ctl", gen_ctl, m_gen);
    case (host_port)
      2'd0: begin erd = (m_idx << 2) | (m_we << 1); chk("R2", "rdata addr", host_rdata, erd); end
      2'd1: begin erd = reg_at(m_idx); chk("R5", "rdata data", host_rdata, erd); end
      2'd2: chk("R8", "rdata clk", host_rdata, m_sel);
      default: chk("R8", "rdata none", host_rdata, 0);
    endcase
  endtask

  // one host cycle, called at a falling edge
  task automatic cyc(input int p, input int we, input int d);
    host_port  = 2'(p);
    host_we    = 1'(we);
    host_wdata = 8'(d);
    @(posedge clk);
    model_step(p, we, d);
    @(negedge clk);
    host_we = 1'b0;
    compare();
  endtask

  task automatic peek(input int p);
    cyc(p, 0, 0);
  endtask

  task automatic reg_write(input int i, input int d);
    cyc(0, 1, (i << 2) | 2);
    cyc(1, 1, d);
    cyc(0, 1, i << 2);
  endtask

  task automatic reg_read(input int i);
    cyc(0, 1, i << 2);
    peek(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state on every port
    for (int p = 0; p < 4; p++) peek(p);

    // R2: bit 0 dropped, permit and index captured
    cyc(0, 1, 8'hFF);
    peek(0);
    cyc(0, 1, (5 << 2) | 1);
    peek(0);

    // R3 / R10: general control write and readback
    reg_write(1, 8'hA5);
    reg_read(1);

    // R6: four distinct codes, walk all clocks
    reg_write(2, 8'b11_10_01_00);
    for (int s = 0; s < 4; s++) cyc(2, 1, s);
    reg_write(2, 8'b00_01_10_11);
    for (int s = 3; s >= 0; s--) cyc(2, 1, s);

    // R7: feedback dividers per clock
    for (int k = 0; k < 4; k++) reg_write(4 + k, 130 + 31*k);
    for (int s = 0; s < 4; s++) begin cyc(2, 1, s); reg_read(4 + s); end

    // R4: permit cleared before a data write
    cyc(0, 1, (4 << 2) | 2);
    cyc(0, 1, 4 << 2);
    cyc(1, 1, 8'h11);
    peek(1);
    cyc(0, 1, 2 << 2);
    cyc(1, 1, 8'h00);
    peek(1);

    // R5: unimplemented indices ignore writes and read zero
    reg_write(0, 8'h5A);
    reg_read(0);
    reg_write(8, 8'h77);
    reg_read(8);
    reg_write(63, 8'hC3);
    reg_read(63);
    for (int k = 1; k < 8; k++) reg_read(k);

    // R9: all extended-control codes, upper bits set too
    for (int c = 0; c < 8; c++) begin reg_write(3, 8'hF8 | c); reg_read(3); end

    // R8: upper clock-control bits dropped, port 3 inert
    cyc(2, 1, 8'hFE);
    peek(2);
    cyc(3, 1, 8'hFF);
    peek(3);
    peek(1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule